// File: doc/BRIEF.md
# Dual-compare retriggerable timer/counter

This block is a 16-bit timer/counter driven by a 16-bit control register. It has a count register and two maximum-count compare registers, A and B. The count can advance from three sources: a fixed divide-by-four of the system clock, a prescale tick from a companion timer, or rising edges of an asynchronous timer input pin. The same pin can instead gate the count or restart it.

When the count reaches the active compare value, the next advance returns the count to zero. That wrap sets a sticky max-count flag. It can also raise a one-clock interrupt request and move the timer output pin. In dual mode the timer alternates between A and B, and the output pin shows which register is in use.

The timer can run continuously or stop after one sequence. In one-shot mode it clears its own enable. Software reaches the four registers through a synchronous write port with a combinational read port.

Top module: `dual_cmp_timer`

## Requirements
- R1: Address 0 selects control, 1 the count, 2 compare A, 3 compare B. Writes take effect at the clock edge where wr_en is high. rdata reflects addr combinationally. After reset every register reads zero, tmr_out is high and irq is low.
- R2: Control bit positions are: continuous 0, alternate 1, external 2, prescale 3, retrigger 4, max-count flag 5, register-in-use 12 (read only), interrupt enable 13, enable-write qualifier 14 (reads 0), enable 15. Every other bit reads zero whatever was written.
- R3: With external set, the count advances once per rising edge of tmr_in, and the prescale and retrigger bits are ignored. A rising edge applied between clock edges shows in the count after the third following rising clock edge, and not after the second.
- R4: With external clear and prescale set, the count advances once per clock in which pre_tick is high. With both clear, it advances exactly once every four clocks.
- R5: With external clear and retrigger set, a rising edge on tmr_in resets the count to zero. With both clear, the count advances only while the synchronized tmr_in is high.
- R6: In single mode (alternate clear), an advance from a count equal to compare A gives zero and sets the max-count flag. The flag stays set until software writes it to zero, so N edges with compare a leave the count at N mod (a+1).
- R7: In dual mode the timer uses A, then B, then A again, each for (compare+1) advances. Bit 12 reads 1 while B is in use and 0 while A is in use. tmr_out is low while B is in use and high while A is in use.
- R8: In single mode, tmr_out goes low for exactly one clock at each wrap.
- R9: With interrupt enable set, irq is high for exactly one clock at each wrap. With it clear, irq stays low.
- R10: With continuous clear, the enable bit clears at the wrap that ends a sequence. In single mode that is every wrap. In dual mode it is only the wrap that ends the B sequence.
- R11: A control write changes the enable bit only when bit 14 is set in the same write. All other writable control bits are written unconditionally.
- R12: While the enable bit is clear, the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| tmr_in | input | 1 | Asynchronous timer input pin |
| pre_tick | input | 1 | One-clock tick from the companion timer at its maximum count |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | One-clock interrupt request |

## Verification
A wrong count or a wrong compare selection shows up in the count read back after the next input edge. Over a sweep of edge counts, the error builds into a residue mismatch. A stale register-in-use state flips tmr_out and bit 12 in dual mode. A lost wrap shows as a missing irq or output pulse within one clock of the wrap. An enable that fails to clear, or clears early, shows as a count that keeps moving, or stops, on the very next edge.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CTL_W  = 16;
  localparam int B_CONT = 0;
  localparam int B_ALT  = 1;
  localparam int B_EXT  = 2;
  localparam int B_PRE  = 3;
  localparam int B_RTG  = 4;
  localparam int B_MC   = 5;
  localparam int B_RIU  = 12;
  localparam int B_INT  = 13;
  localparam int B_INH  = 14;
  localparam int B_EN   = 15;

  // bits that may read back as one
  localparam logic [CTL_W-1:0] READ_MASK = 16'hB03F;

  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMPA = 2'd2,
    REG_CMPB = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic int_en;
    logic mc;
    logic rtg;
    logic pre;
    logic ext;
    logic alt;
    logic cont;
  } ctl_t;
endpackage

// File: rtl/dct_sync_edge.sv
module dct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;

  // a detected edge lasts one clock only (R3)
  p_rise_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/dct_tick_sel.sv
module dct_tick_sel #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext,
  input  logic use_pre,
  input  logic in_rise,
  input  logic pre_tick,
  output logic adv
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic          div_tick;

  assign div_tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (div_tick) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  always_comb begin
    if (ext)          adv = in_rise;
    else if (use_pre) adv = pre_tick;
    else              adv = div_tick;
  end

  // divided tick never fires on two adjacent clocks (R4)
  p_div_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick);
endmodule

// File: rtl/dct_core.sv
module dct_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         retrig,
  input  logic         gate_ok,
  input  logic         en,
  input  logic         alt,
  input  logic         cont,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] cnt_q,
  output logic         use_b,
  output logic         max_evt,
  output logic         stop_req
);
  function automatic logic [W-1:0] pick_cmp(input logic sel_b,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    return sel_b ? b : a;
  endfunction

  function automatic logic at_max(input logic [W-1:0] c, input logic [W-1:0] m);
    return c == m;
  endfunction

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                              input logic [W-1:0] m);
    return at_max(c, m) ? '0 : c + 1'b1;
  endfunction

  logic [W-1:0] cmp_now;
  logic         step;

  assign cmp_now  = pick_cmp(alt & use_b, cmp_a, cmp_b);
  assign step     = en & gate_ok & adv & ~cnt_wr & ~retrig;
  assign max_evt  = step & at_max(cnt_q, cmp_now);
  assign stop_req = max_evt & ~cont & (~alt | use_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      use_b <= 1'b0;
    end else begin
      if (cnt_wr)      cnt_q <= cnt_wdata;
      else if (retrig) cnt_q <= '0;
      else if (step)   cnt_q <= next_count(cnt_q, cmp_now);
      if (!alt)         use_b <= 1'b0;
      else if (max_evt) use_b <= ~use_b;
    end
  end

  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    max_evt |=> cnt_q == '0);
  p_single_uses_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !alt |=> !use_b);
  p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr && !retrig) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int W         = 16,
  parameter int DIV       = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         tmr_in,
  input  logic         pre_tick,
  output logic         tmr_out,
  output logic         irq
);
  ctl_t         ctl_q;
  logic [W-1:0] cmp_a_q, cmp_b_q, cnt_q;
  logic         in_level, in_rise, adv, use_b, max_evt, stop_req;
  logic         ctl_wr, cnt_wr, gate_ok, retrig;
  logic         irq_q, out_low_q;

  assign ctl_wr  = wr_en && (addr == REG_CTL);
  assign cnt_wr  = wr_en && (addr == REG_CNT);
  assign gate_ok = ctl_q.ext | ctl_q.rtg | in_level;
  assign retrig  = ~ctl_q.ext & ctl_q.rtg & in_rise;

  dct_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(tmr_in),
    .level(in_level), .rise(in_rise)
  );

  dct_tick_sel #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext(ctl_q.ext), .use_pre(ctl_q.pre),
    .in_rise(in_rise), .pre_tick(pre_tick), .adv(adv)
  );

  dct_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .retrig(retrig), .gate_ok(gate_ok),
    .en(ctl_q.en), .alt(ctl_q.alt), .cont(ctl_q.cont), .cnt_wr(cnt_wr),
    .cnt_wdata(wdata), .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .cnt_q(cnt_q),
    .use_b(use_b), .max_evt(max_evt), .stop_req(stop_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      cmp_a_q   <= '0;
      cmp_b_q   <= '0;
      irq_q     <= 1'b0;
      out_low_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_q.cont   <= wdata[B_CONT];
        ctl_q.alt    <= wdata[B_ALT];
        ctl_q.ext    <= wdata[B_EXT];
        ctl_q.pre    <= wdata[B_PRE];
        ctl_q.rtg    <= wdata[B_RTG];
        ctl_q.int_en <= wdata[B_INT];
      end
      if (ctl_wr && wdata[B_INH]) ctl_q.en <= wdata[B_EN];
      else if (stop_req)          ctl_q.en <= 1'b0;
      if (max_evt)     ctl_q.mc <= 1'b1;
      else if (ctl_wr) ctl_q.mc <= wdata[B_MC];
      if (wr_en && addr == REG_CMPA) cmp_a_q <= wdata;
      if (wr_en && addr == REG_CMPB) cmp_b_q <= wdata;
      irq_q     <= max_evt & ctl_q.int_en;
      out_low_q <= max_evt & ~ctl_q.alt;
    end
  end

  assign irq     = irq_q;
  assign tmr_out = ctl_q.alt ? ~use_b : ~out_low_q;

  always_comb begin
    rdata = '0;
    case (addr)
      REG_CTL: begin
        rdata[B_CONT] = ctl_q.cont;
        rdata[B_ALT]  = ctl_q.alt;
        rdata[B_EXT]  = ctl_q.ext;
        rdata[B_PRE]  = ctl_q.pre;
        rdata[B_RTG]  = ctl_q.rtg;
        rdata[B_MC]   = ctl_q.mc;
        rdata[B_RIU]  = use_b;
        rdata[B_INT]  = ctl_q.int_en;
        rdata[B_EN]   = ctl_q.en;
      end
      REG_CNT:  rdata = cnt_q;
      REG_CMPA: rdata = cmp_a_q;
      default:  rdata = cmp_b_q;
    endcase
  end

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_CTL) |-> (rdata[CTL_W-1:0] & ~READ_MASK) == '0);
  p_irq_with_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_q.mc);
  p_en_needs_qual_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[B_INH] && !stop_req) |=> ctl_q.en == $past(ctl_q.en));
  p_oneshot_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !(ctl_wr && wdata[B_INH])) |=> !ctl_q.en);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.alt && !tmr_out) |=> tmr_out || $past(max_evt) == 1'b0);
endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  localparam logic [15:0] CONT = 16'h0001, ALT = 16'h0002, EXT = 16'h0004,
                          PRE = 16'h0008, RTG = 16'h0010, MC = 16'h0020,
                          RIU = 16'h1000, INTE = 16'h2000, INH = 16'h4000,
                          EN = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic tmr_in = 1'b0;
  logic pre_tick = 1'b0;
  logic tmr_out, irq;
  int vecs = 0, miss = 0, irq_seen = 0, low_seen = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tmr_in(tmr_in), .pre_tick(pre_tick),
    .tmr_out(tmr_out), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_seen++;
    if (!tmr_out) low_seen++;
  end

  task automatic chk(input int act, input int exp, input string tag);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_in(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_in = 1'b1;
      repeat (3) @(negedge clk);
      tmr_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pre_tick = 1'b1;
      @(negedge clk); pre_tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      miss++; vecs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk(v, 0, "R1 reset reg");
    end
    chk(tmr_out, 1, "R1 reset tmr_out");
    chk(irq, 0, "R1 reset irq");
    wr(2, 16'h1234); wr(3, 16'hBEEF); wr(1, 16'h0042);
    rd(2, v); chk(v, 16'h1234, "R1 cmpA");
    rd(3, v); chk(v, 16'hBEEF, "R1 cmpB");
    rd(1, v); chk(v, 16'h0042, "R1 count");

    // R2 field layout and reserved bits
    wr(0, 16'hFFFF);
    rd(0, v); chk(v, 16'hA03F, "R2 readback all ones");
    wr(0, INH);
    rd(0, v); chk(v, 0, "R2 cleared");

    // R11 enable only with qualifier, R12 no advance while disabled
    wr(1, 0); wr(2, 16'hFFFF);
    wr(0, EN | EXT | CONT);
    rd(0, v); chk(v & EN, 0, "R11 enable without qualifier");
    pulse_in(3);
    rd(1, v); chk(v, 0, "R12 disabled count holds");
    wr(0, INH | EN | EXT | CONT);
    wr(0, EXT | CONT);
    rd(0, v); chk(v & EN, EN, "R11 enable kept without qualifier");

    // R3 latency and ignored prescale / retrigger
    wr(0, INH | EN | EXT | CONT); wr(1, 0);
    @(negedge clk); tmr_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(1, v); chk(v, 0, "R3 not yet after two edges");
    @(negedge clk);
    rd(1, v); chk(v, 1, "R3 counted after third edge");
    tmr_in = 1'b0; repeat (3) @(negedge clk);
    wr(0, INH | EN | EXT | PRE | RTG | CONT); wr(1, 5);
    ticks(4);
    rd(1, v); chk(v, 5, "R3 prescale ignored");
    pulse_in(1);
    rd(1, v); chk(v, 6, "R3 retrigger ignored");

    // R4 prescale and divide-by-four
    wr(0, INH | EN | PRE | RTG | CONT); wr(1, 0);
    ticks(7);
    rd(1, v); chk(v, 7, "R4 prescale ticks");
    wr(0, INH | EN | RTG | CONT);
    rd(1, v0);
    repeat (40) @(negedge clk);
    rd(1, v); chk(v - v0, 10, "R4 one per four clocks");

    // R5 retrigger and gate
    wr(0, INH | EN | PRE | RTG | CONT); wr(1, 0);
    ticks(5);
    rd(1, v); chk(v, 5, "R5 before retrigger");
    pulse_in(1);
    rd(1, v); chk(v, 0, "R5 retrigger resets");
    ticks(2);
    rd(1, v); chk(v, 2, "R5 counts after retrigger");
    wr(0, INH | EN | PRE | CONT); wr(1, 0);
    ticks(4);
    rd(1, v); chk(v, 0, "R5 gate low holds");
    tmr_in = 1'b1; repeat (4) @(negedge clk);
    ticks(3);
    rd(1, v); chk(v, 3, "R5 gate high counts");
    tmr_in = 1'b0; repeat (4) @(negedge clk);
    ticks(2);
    rd(1, v); chk(v, 3, "R5 gate closed again");

    // R6 R8 R9 single-mode sweep
    for (int a = 0; a < 5; a++) begin
      for (int n = 0; n < 10; n++) begin
        int i0, l0;
        wr(0, INH); wr(2, 16'(a)); wr(1, 0);
        wr(0, INH | EN | EXT | CONT | INTE);
        i0 = irq_seen; l0 = low_seen;
        pulse_in(n);
        rd(1, v); chk(v, n % (a + 1), "R6 residue");
        rd(0, v); chk((v & MC) != 0, n > a, "R6 max-count flag");
        chk(irq_seen - i0, n / (a + 1), "R9 irq pulses");
        chk(low_seen - l0, n / (a + 1), "R8 output pulses");
      end
    end
    // R9 no irq with interrupt disabled
    wr(0, INH); wr(2, 1); wr(1, 0);
    wr(0, INH | EN | EXT | CONT);
    v0 = 16'(irq_seen);
    pulse_in(4);
    chk(irq_seen - int'(v0), 0, "R9 irq suppressed");
    wr(0, INH | EN | EXT | CONT);
    rd(0, v); chk(v & MC, 0, "R6 flag cleared by write");

    // R7 dual-mode sweep
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int n = 0; n < 9; n++) begin
          int r, ec, eb;
          r = n % (a + b + 2);
          eb = (r > a) ? 1 : 0;
          ec = eb ? r - (a + 1) : r;
          wr(0, INH); wr(2, 16'(a)); wr(3, 16'(b)); wr(1, 0);
          wr(0, INH | EN | EXT | CONT | ALT);
          pulse_in(n);
          rd(1, v); chk(v, ec, "R7 dual count");
          rd(0, v); chk((v & RIU) != 0, eb, "R7 register in use");
          chk(tmr_out, !eb, "R7 output level");
        end
      end
    end

    // R10 one-shot, single then dual
    wr(0, INH); wr(2, 2); wr(1, 0);
    wr(0, INH | EN | EXT);
    pulse_in(3);
    rd(0, v); chk(v & (EN | MC), MC, "R10 single one-shot stops");
    pulse_in(2);
    rd(1, v); chk(v, 0, "R12 count frozen after stop");
    wr(0, INH); wr(2, 1); wr(3, 1); wr(1, 0);
    wr(0, INH | EN | EXT | ALT);
    pulse_in(2);
    rd(0, v); chk(v & (EN | RIU), EN | RIU, "R10 dual runs through A");
    pulse_in(2);
    rd(0, v); chk(v & EN, 0, "R10 dual stops after B");
    pulse_in(1);
    rd(1, v); chk(v, 0, "R10 no advance after stop");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule